// File: doc/BRIEF.md
# Autoregressive Token Generation Sequencer

This block is the control loop that runs a fixed chain of compute stages once for each generated token. It starts from a seed token id. For every token it fires, one after another, an embedding stage, four block stages and an output projection stage. Each stage gets a one-cycle start pulse, and the sequencer waits for that stage's done pulse before moving on.

When the projection has finished, the sequencer waits until an argmax result has been captured. It presents that token on its output with a one-cycle strobe and feeds it back as the token id for the next embedding lookup. A separate capture register with its own flag takes the argmax result whenever its valid pulse arrives, so the state machine never depends on the exact cycle of that pulse. After a fixed number of tokens the sequencer parks in a terminal state.

The compute stages are not part of this block. They connect through the start and done vectors, the current-token output and the argmax result inputs.

Top module: `tok_gen_sequencer`

## Requirements
- R1: While reset is high, and in the cycle after it is released, no start bit is set, `out_valid` and `gen_done` are low and `cur_token` equals the seed parameter (default 42).
- R2: After reset the sequencer stays idle and raises no start bit until `go` is sampled high. It then raises the embedding start on the next cycle.
- R3: Start pulses are exactly one cycle wide and never more than one bit at a time. For every token they come in the fixed order bit 0 (embedding), bits 1 to 4 (blocks 1 to 4), bit 5 (output projection).
- R4: After a start pulse on bit k the sequencer waits until `stage_done[k]` is sampled high. A done pulse on any other bit during that wait has no effect, and no further start appears.
- R5: `cur_token` equals the seed for the first token. One cycle after each output strobe it equals the token just emitted, which becomes the next input token id.
- R6: The output strobe `out_valid` is a one-cycle pulse. It is raised only after an argmax result has been captured during the current token, because the capture flag is cleared when the embedding start of each token is issued.
- R7: `out_token` equals the `argmax_token` value sampled together with `argmax_valid`, regardless of later changes on `argmax_token`.
- R8: After MAX_GEN output strobes (default 16) the sequencer raises `gen_done` and holds it, ignoring `go` and raising no more starts. A reset clears the token count, so a full new run of MAX_GEN tokens follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | Begins generation when sampled in the idle state |
| stage_start | output | 6 | One-cycle start pulses: bit 0 embedding, bits 1-4 blocks, bit 5 projection |
| stage_done | input | 6 | Done pulses from the stages, same bit mapping |
| cur_token | output | TOK_W (7) | Token id supplied to the embedding stage |
| argmax_valid | input | 1 | Argmax result strobe |
| argmax_token | input | TOK_W (7) | Argmax result token id |
| out_valid | output | 1 | One-cycle strobe for each generated token |
| out_token | output | TOK_W (7) | Generated token id, valid with out_valid |
| gen_done | output | 1 | High once all MAX_GEN tokens are produced |

## Verification
Each of the sixteen tokens is driven with its own mix of stage latencies, from zero to three cycles. This separates a sequencer that waits on the matching done pulse from one that advances on a count or on any done bit. A spurious done on a neighbouring stage bit is injected during most waits, which exposes decoding of the wrong bit. The argmax pulse arrives either together with the projection done or one to two cycles later. That distinguishes a properly cleared capture flag from a stale one, and latching on the valid pulse from following `argmax_token` afterwards. Because the expected tokens come from a fixed arithmetic map of the previous token, a broken feedback path changes every following value. Runs that end by reset in mid-generation check that the seed and the counter are restored.

// File: rtl/tgs_pkg.sv
package tgs_pkg;

   localparam int unsigned NUM_STAGES = 6;
   localparam int unsigned ST_W       = 4;
   localparam int unsigned STG_IDX_W  = $clog2(NUM_STAGES);

   // Start states carry odd codes, run states even codes; stage k starts at 2k+1.
   typedef enum logic [ST_W-1:0] {
      S_IDLE     = 4'd0,
      S_EMB_GO   = 4'd1,
      S_EMB_RUN  = 4'd2,
      S_B1_GO    = 4'd3,
      S_B1_RUN   = 4'd4,
      S_B2_GO    = 4'd5,
      S_B2_RUN   = 4'd6,
      S_B3_GO    = 4'd7,
      S_B3_RUN   = 4'd8,
      S_B4_GO    = 4'd9,
      S_B4_RUN   = 4'd10,
      S_PRJ_GO   = 4'd11,
      S_PRJ_RUN  = 4'd12,
      S_ARG_WAIT = 4'd13,
      S_EMIT     = 4'd14,
      S_HALT     = 4'd15
   } tgs_state_e;

   function automatic logic is_run(tgs_state_e s);
      logic [ST_W-1:0] v;
      v = s;
      return (v >= 4'd2) && (v <= 4'd12) && !v[0];
   endfunction

   function automatic logic [STG_IDX_W-1:0] run_stage(tgs_state_e s);
      logic [ST_W-1:0] v;
      v = s;
      return STG_IDX_W'((v - 4'd2) >> 1);
   endfunction

endpackage

// File: rtl/tgs_gen_count.sv
module tgs_gen_count #(
   parameter int unsigned MAX_GEN = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic bump_i,
   output logic last_o
);
   localparam int unsigned CNT_W = (MAX_GEN > 1) ? $clog2(MAX_GEN) : 1;
   localparam logic [CNT_W-1:0] LAST_V = CNT_W'(MAX_GEN - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (bump_i && !last_o) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign last_o = (cnt_q == LAST_V);

   // R8: each emitted token advances the count by one until the last one
   p_count_step_r8: assert property (@(posedge clk) disable iff (rst)
      (bump_i && !last_o) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/tgs_tok_loop.sv
module tgs_tok_loop #(
   parameter int unsigned TOK_W = 7,
   parameter int unsigned SEED  = 42
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clear_i,
   input  logic             res_valid_i,
   input  logic [TOK_W-1:0] res_tok_i,
   input  logic             load_i,
   output logic [TOK_W-1:0] cur_tok_o,
   output logic [TOK_W-1:0] cap_tok_o,
   output logic             got_o
);
   localparam logic [TOK_W-1:0] SEED_V = TOK_W'(SEED);

   logic [TOK_W-1:0] cur_q;
   logic [TOK_W-1:0] cap_q;
   logic             got_q;

   // Result capture: a new iteration discards anything captured before it.
   always_ff @(posedge clk) begin
      if (rst) begin
         got_q <= 1'b0;
         cap_q <= '0;
      end else if (clear_i) begin
         got_q <= 1'b0;
      end else if (res_valid_i) begin
         got_q <= 1'b1;
         cap_q <= res_tok_i;
      end
   end

   // Feedback register: seed after reset, emitted token afterwards.
   always_ff @(posedge clk) begin
      if (rst) begin
         cur_q <= SEED_V;
      end else if (load_i) begin
         cur_q <= cap_q;
      end
   end

   assign cur_tok_o = cur_q;
   assign cap_tok_o = cap_q;
   assign got_o     = got_q;

   // R7: a result strobe outside an iteration start is held with its flag
   p_capture_r7: assert property (@(posedge clk) disable iff (rst)
      (res_valid_i && !clear_i) |=> (got_q && cap_q == $past(res_tok_i)));

   // R6: the flag never survives an iteration start
   p_flag_clear_r6: assert property (@(posedge clk) disable iff (rst)
      clear_i |=> !got_q);

   // R5: the token being emitted becomes the next input token
   p_feedback_r5: assert property (@(posedge clk) disable iff (rst)
      load_i |=> (cur_q == $past(cap_q)));

endmodule

// File: rtl/tgs_ctrl_fsm.sv
module tgs_ctrl_fsm
   import tgs_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  go_i,
   input  logic [NUM_STAGES-1:0] stage_done_i,
   input  logic                  got_i,
   input  logic                  last_i,
   output tgs_state_e            state_o,
   output logic [NUM_STAGES-1:0] stage_start_o
);
   tgs_state_e st_q;
   tgs_state_e st_d;

   always_comb begin
      st_d = st_q;
      case (st_q)
         S_IDLE: begin
            if (go_i) st_d = S_EMB_GO;
         end
         S_EMB_GO, S_B1_GO, S_B2_GO, S_B3_GO, S_B4_GO, S_PRJ_GO: begin
            st_d = tgs_state_e'(st_q + 4'd1);
         end
         S_EMB_RUN, S_B1_RUN, S_B2_RUN, S_B3_RUN, S_B4_RUN, S_PRJ_RUN: begin
            if (stage_done_i[run_stage(st_q)]) st_d = tgs_state_e'(st_q + 4'd1);
         end
         S_ARG_WAIT: begin
            if (got_i) st_d = S_EMIT;
         end
         S_EMIT: begin
            st_d = last_i ? S_HALT : S_EMB_GO;
         end
         S_HALT: begin
            st_d = S_HALT;
         end
         default: st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) st_q <= S_IDLE;
      else     st_q <= st_d;
   end

   for (genvar k = 0; k < NUM_STAGES; k++) begin : g_start
      assign stage_start_o[k] = (st_q == tgs_state_e'(ST_W'(2 * k + 1)));
   end

   assign state_o = st_q;

   // R3: a start pulse lasts one cycle
   p_start_pulse_r3: assert property (@(posedge clk) disable iff (rst)
      (|stage_start_o) |=> !(|stage_start_o));

   // R3: never two stages started at once
   p_start_single_r3: assert property (@(posedge clk) disable iff (rst)
      $onehot0(stage_start_o));

   // R4: a run state holds until its own stage reports done
   p_run_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (is_run(st_q) && !stage_done_i[run_stage(st_q)]) |=> $stable(st_q));

   // R2: idle holds without go
   p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
      (st_q == S_IDLE && !go_i) |=> (st_q == S_IDLE));

   // R8: the terminal state is never left without reset
   p_halt_sticky_r8: assert property (@(posedge clk) disable iff (rst)
      (st_q == S_HALT) |=> (st_q == S_HALT));

endmodule

// File: rtl/tok_gen_sequencer.sv
module tok_gen_sequencer
   import tgs_pkg::*;
#(
   parameter int unsigned TOK_W      = 7,
   parameter int unsigned VOCAB      = 128,
   parameter int unsigned MAX_GEN    = 16,
   parameter int unsigned SEED_TOKEN = 42
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  go,
   output logic [NUM_STAGES-1:0] stage_start,
   input  logic [NUM_STAGES-1:0] stage_done,
   output logic [TOK_W-1:0]      cur_token,
   input  logic                  argmax_valid,
   input  logic [TOK_W-1:0]      argmax_token,
   output logic                  out_valid,
   output logic [TOK_W-1:0]      out_token,
   output logic                  gen_done
);
   if (TOK_W < 1 || VOCAB > (1 << TOK_W)) begin : g_bad_width
      $error("tok_gen_sequencer: vocabulary does not fit token width");
   end
   if (SEED_TOKEN >= VOCAB) begin : g_bad_seed
      $error("tok_gen_sequencer: seed token outside vocabulary");
   end
   if (MAX_GEN < 1) begin : g_bad_count
      $error("tok_gen_sequencer: at least one token must be generated");
   end

   tgs_state_e       state;
   logic             got;
   logic             last;
   logic             emit;
   logic             iter_start;
   logic [TOK_W-1:0] cap_tok;

   tgs_ctrl_fsm i_fsm (
      .clk           (clk),
      .rst           (rst),
      .go_i          (go),
      .stage_done_i  (stage_done),
      .got_i         (got),
      .last_i        (last),
      .state_o       (state),
      .stage_start_o (stage_start)
   );

   assign emit       = (state == S_EMIT);
   assign iter_start = stage_start[0];

   tgs_tok_loop #(
      .TOK_W (TOK_W),
      .SEED  (SEED_TOKEN)
   ) i_loop (
      .clk         (clk),
      .rst         (rst),
      .clear_i     (iter_start),
      .res_valid_i (argmax_valid),
      .res_tok_i   (argmax_token),
      .load_i      (emit),
      .cur_tok_o   (cur_token),
      .cap_tok_o   (cap_tok),
      .got_o       (got)
   );

   tgs_gen_count #(
      .MAX_GEN (MAX_GEN)
   ) i_count (
      .clk    (clk),
      .rst    (rst),
      .bump_i (emit),
      .last_o (last)
   );

   assign out_valid = emit;
   assign out_token = cap_tok;
   assign gen_done  = (state == S_HALT);

   // R6: the output strobe is a single cycle
   p_emit_pulse_r6: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid);

   // R6: no emission before a result has been captured
   p_arg_gate_r6: assert property (@(posedge clk) disable iff (rst)
      (state == S_ARG_WAIT && !got) |=> !out_valid);

   // R5: emitted token is fed back as the next input
   p_loop_back_r5: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> (cur_token == $past(out_token)));

endmodule

// File: tb/test_tok_gen_sequencer.sv
module test_tok_gen_sequencer;
   localparam int TOK_W   = 7;
   localparam int VOCAB   = 128;
   localparam int MAX_GEN = 16;
   localparam int SEED    = 42;
   localparam int NST     = 6;

   logic             clk = 1'b0;
   logic             rst;
   logic             go;
   logic [NST-1:0]   stage_start;
   logic [NST-1:0]   stage_done;
   logic [TOK_W-1:0] cur_token;
   logic             argmax_valid;
   logic [TOK_W-1:0] argmax_token;
   logic             out_valid;
   logic [TOK_W-1:0] out_token;
   logic             gen_done;

   int  n_run  = 0;
   int  n_fail = 0;
   bit  ended  = 0;

   always #4 clk = ~clk;

   tok_gen_sequencer #(
      .TOK_W (TOK_W), .VOCAB (VOCAB), .MAX_GEN (MAX_GEN), .SEED_TOKEN (SEED)
   ) i_tok_gen_sequencer (
      .clk (clk), .rst (rst), .go (go),
      .stage_start (stage_start), .stage_done (stage_done),
      .cur_token (cur_token),
      .argmax_valid (argmax_valid), .argmax_token (argmax_token),
      .out_valid (out_valid), .out_token (out_token), .gen_done (gen_done)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int next_tok(input int t);
      return (t * 37 + 11) % VOCAB;
   endfunction

   task automatic check_reset_state();
      chk("R1", "stage_start", int'(stage_start), 0);
      chk("R1", "out_valid", int'(out_valid), 0);
      chk("R1", "gen_done", int'(gen_done), 0);
      chk("R1", "cur_token", int'(cur_token), SEED);
   endtask

   // Runs ntok tokens from the seed, acting as all stage stubs and argmax.
   task automatic run_gen(input int ntok, output int emitted);
      int exp_in;
      int exp_out;
      emitted = 0;
      exp_in  = SEED;
      @(negedge clk); go = 1'b1;
      @(negedge clk); go = 1'b0;
      for (int t = 0; t < ntok; t++) begin
         int a;
         int found;
         exp_out = next_tok(exp_in);
         a = t % 3;
         for (int k = 0; k < NST; k++) begin
            int lat;
            found = 0;
            for (int i = 0; i < 20; i++) begin
               if (stage_start != 0) begin found = 1; break; end
               @(negedge clk);
            end
            chk("R3", "start seen", found, 1);
            chk("R3", "start order", int'(stage_start), 1 << k);
            if (k == 0) chk("R5", "input token", int'(cur_token), exp_in);
            @(negedge clk);
            chk("R3", "start width", int'(stage_start), 0);
            lat = (t + k) % 4;
            for (int j = 0; j < lat; j++) begin
               if (j == 0) stage_done[(k + 1) % NST] = 1'b1;
               @(negedge clk);
               stage_done = '0;
               chk("R4", "held in run", int'(stage_start), 0);
            end
            stage_done[k] = 1'b1;
            if (k == NST - 1 && a == 0) begin
               argmax_valid = 1'b1;
               argmax_token = TOK_W'(exp_out);
            end
            @(negedge clk);
            stage_done   = '0;
            argmax_valid = 1'b0;
            argmax_token = TOK_W'(~exp_out);
         end
         if (a > 0) begin
            for (int j = 0; j < a; j++) begin
               chk("R6", "no early strobe", int'(out_valid), 0);
               if (j == a - 1) begin
                  argmax_valid = 1'b1;
                  argmax_token = TOK_W'(exp_out);
               end
               @(negedge clk);
            end
            argmax_valid = 1'b0;
            argmax_token = TOK_W'(~exp_out);
         end
         found = 0;
         for (int i = 0; i < 10; i++) begin
            if (out_valid) begin found = 1; break; end
            @(negedge clk);
         end
         chk("R6", "strobe seen", found, 1);
         chk("R7", "out_token", int'(out_token), exp_out);
         emitted++;
         @(negedge clk);
         chk("R6", "strobe width", int'(out_valid), 0);
         chk("R5", "fed back", int'(cur_token), exp_out);
         exp_in = exp_out;
      end
   endtask

   initial begin
      int em;
      rst = 1'b1; go = 1'b0; stage_done = '0;
      argmax_valid = 1'b0; argmax_token = '0;
      repeat (3) @(negedge clk);
      check_reset_state();
      rst = 1'b0;
      @(negedge clk);
      check_reset_state();
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk("R2", "idle without go", int'(stage_start), 0);
      end
      run_gen(MAX_GEN, em);
      chk("R8", "tokens emitted", em, MAX_GEN);
      chk("R8", "gen_done", int'(gen_done), 1);
      go = 1'b1;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         go = 1'b0;
         chk("R8", "no start after halt", int'(stage_start), 0);
         chk("R8", "no strobe after halt", int'(out_valid), 0);
         chk("R8", "gen_done held", int'(gen_done), 1);
      end
      rst = 1'b1;
      @(negedge clk);
      check_reset_state();
      rst = 1'b0;
      run_gen(3, em);
      chk("R8", "partial run", em, 3);
      rst = 1'b1;
      @(negedge clk);
      check_reset_state();
      rst = 1'b0;
      @(negedge clk);
      chk("R2", "idle after reset", int'(stage_start), 0);
      run_gen(MAX_GEN, em);
      chk("R8", "tokens after reset", em, MAX_GEN);
      chk("R8", "gen_done again", int'(gen_done), 1);
      if (!ended) begin
         ended = 1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!ended) begin
         ended = 1;
         n_run++;
         n_fail++;
         $display("FAIL R8 watchdog: actual %0d cycles expected completion", 100000);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule